// File: doc/BRIEF.md
# Shift-Insert Constant Builder

This execution unit builds wide constants for a 64-bit register machine out of short chains of literal-insert operations. A decoded operation code, a source operand, the current destination value, an immediate literal and a destination register index arrive together with an input valid. The unit computes a single result and holds it in an output register. One clock after an accepted operation, it raises an output valid.

Five operations are available:

- A 16-bit insert shifts the source left by sixteen and places the literal in the freed low bits.
- An inverted 16-bit insert does the same with the bitwise complement of the literal. This shortens sequences for negative values.
- A 22-bit accumulate shifts the destination's own prior value left by twenty-two and places the literal below it.
- A 22-bit initial load sign-extends the literal.
- A 25-bit load sign-extends its literal and always writes a fixed register.

A full 64-bit constant takes four 16-bit inserts when the first one starts from a zero source. It takes three 22-bit steps when an initial load is followed by two accumulates.

Top module: `cb_const_builder`

## Requirements
- R1: Operation code 0 (insert) yields (src << 16) | lit, where lit is imm[15:0] zero-extended; the shift is logical within 64 bits and bits moved past bit 63 are lost.
- R2: Operation code 1 (inverted insert) yields (src << 16) | (~imm[15:0]). The complement covers only the 16-bit field, and bits 63:16 come unchanged from the shifted source.
- R3: Operation code 2 (accumulate) yields (dst << 22) | imm[21:0] zero-extended. It uses the destination operand, not the source.
- R4: Operation code 3 (initial load) yields imm[21:0] sign-extended to 64 bits from bit 21.
- R5: Operation code 4 (fixed load) yields imm[24:0] sign-extended from bit 24, and reports register index FIXED_REG (default 0) on out_rd instead of in_rd.
- R6: Immediate bits above the width an operation uses have no effect on its result.
- R7: For a legal operation accepted with in_valid high, out_valid is high in the next cycle, with the result on out_result and in_rd on out_rd. When in_valid is low, out_valid drops in the next cycle and out_result and out_rd keep their values.
- R8: Operation codes 5, 6 and 7 are not accepted. out_valid is low in the next cycle and out_result and out_rd are unchanged.
- R9: While rst_n is low, out_valid, out_result and out_rd are all zero.
- R10: Four back-to-back code-0 steps, the first with a zero source and each later one taking the previous result as its source, with literals taken from bits 63:48, 47:32, 31:16 and 15:0 of a constant in that order, leave that constant on out_result.
- R11: A code-3 step with literal {c[63],c[63],c[63:44]}, followed by code-2 steps with c[43:22] and c[21:0] that each take the previous result as the destination, leaves c on out_result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Operation code (0..4 legal) |
| in_rd | input | 5 | Destination register index |
| in_src | input | 64 | Source operand |
| in_dst | input | 64 | Current destination value |
| in_imm | input | 25 | Immediate literal |
| out_valid | output | 1 | Result valid, one cycle after acceptance |
| out_rd | output | 5 | Register index the result is written to |
| out_result | output | 64 | Registered result |

## Verification
The bench uses the default parameters: a 64-bit datapath, 16-, 22- and 25-bit literal fields, a 5-bit register index and a fixed register index of 0. At these widths, random 64-bit constants can pass through the full four-step 16-bit chain and the full three-step 22-bit chain. The sign bits at positions 21 and 24 and the discard of bits shifted past bit 63 are also exercised at their real positions. A behavioural model in the bench predicts out_valid, out_rd and out_result every cycle. This includes the hold cases for idle cycles and for illegal codes, and the garbage placed in unused immediate bits.

// File: rtl/cb_pkg.sv
package cb_pkg;

   localparam int CB_OP_W = 3;

   typedef enum logic [CB_OP_W-1:0] {
      CB_INS16   = 3'd0,
      CB_INSN16  = 3'd1,
      CB_ACC22   = 3'd2,
      CB_INIT22  = 3'd3,
      CB_LDFIX25 = 3'd4
   } cb_op_e;

   localparam int CB_NUM_OPS = 5;

   typedef struct packed {
      logic ins;
      logic insn;
      logic acc;
      logic init;
      logic ldfix;
   } cb_sel_t;

endpackage

// File: rtl/cb_insert_lane.sv
// Shifts a base value left by the literal width and fills the low bits
// with the literal, optionally complemented (field only).
module cb_insert_lane #(
   parameter int XLEN   = 64,
   parameter int LIT_W  = 16,
   parameter bit INVERT = 1'b0
) (
   input  logic [XLEN-1:0]  base,
   input  logic [LIT_W-1:0] lit,
   output logic [XLEN-1:0]  res
);
   localparam int KEEP_W = XLEN - LIT_W;

   generate
      if (LIT_W < 1 || LIT_W >= XLEN) begin : g_bad_width
         $error("cb_insert_lane: LIT_W must lie in 1..XLEN-1");
      end
   endgenerate

   logic [LIT_W-1:0]  lit_eff;
   logic [KEEP_W-1:0] kept;

   generate
      if (INVERT) begin : g_inv
         assign lit_eff = ~lit;
      end else begin : g_pass
         assign lit_eff = lit;
      end
   endgenerate

   assign kept = base[KEEP_W-1:0];
   assign res  = {kept, lit_eff};

   logic unused_top;
   assign unused_top = ^base[XLEN-1:KEEP_W];
endmodule

// File: rtl/cb_sext_lane.sv
// Sign-extends a literal of width LIT_W to XLEN bits.
module cb_sext_lane #(
   parameter int XLEN  = 64,
   parameter int LIT_W = 22
) (
   input  logic [LIT_W-1:0] lit,
   output logic [XLEN-1:0]  res
);
   generate
      if (LIT_W < 1 || LIT_W > XLEN) begin : g_bad_width
         $error("cb_sext_lane: LIT_W must lie in 1..XLEN");
      end else if (LIT_W == XLEN) begin : g_full
         assign res = lit;
      end else begin : g_ext
         localparam int EXT_W = XLEN - LIT_W;
         assign res = {{EXT_W{lit[LIT_W-1]}}, lit};
      end
   endgenerate
endmodule

// File: rtl/cb_op_decode.sv
// Turns the operation code into a one-hot lane select plus a legal flag.
module cb_op_decode
   import cb_pkg::*;
(
   input  logic [CB_OP_W-1:0] op,
   output cb_sel_t            sel,
   output logic               legal
);
   always_comb begin
      sel = '0;
      unique case (op)
         CB_INS16:   sel.ins   = 1'b1;
         CB_INSN16:  sel.insn  = 1'b1;
         CB_ACC22:   sel.acc   = 1'b1;
         CB_INIT22:  sel.init  = 1'b1;
         CB_LDFIX25: sel.ldfix = 1'b1;
         default:    sel       = '0;
      endcase
   end

   assign legal = |sel;
endmodule

// File: rtl/cb_const_builder.sv
module cb_const_builder
   import cb_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int NARROW_W  = 16,
   parameter int WIDE_W    = 22,
   parameter int LOAD_W    = 25,
   parameter int IMM_W     = 25,
   parameter int RIDX_W    = 5,
   parameter int FIXED_REG = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [CB_OP_W-1:0]  in_op,
   input  logic [RIDX_W-1:0]   in_rd,
   input  logic [XLEN-1:0]     in_src,
   input  logic [XLEN-1:0]     in_dst,
   input  logic [IMM_W-1:0]    in_imm,
   output logic                out_valid,
   output logic [RIDX_W-1:0]   out_rd,
   output logic [XLEN-1:0]     out_result
);
   localparam int MAX_LIT = (LOAD_W > WIDE_W) ?
                            ((LOAD_W > NARROW_W) ? LOAD_W : NARROW_W) :
                            ((WIDE_W > NARROW_W) ? WIDE_W : NARROW_W);
   localparam logic [RIDX_W-1:0] FIXED_IDX = RIDX_W'(FIXED_REG);

   generate
      if (IMM_W < MAX_LIT) begin : g_bad_imm
         $error("cb_const_builder: IMM_W narrower than the widest literal");
      end
      if (FIXED_REG < 0 || FIXED_REG >= (1 << RIDX_W)) begin : g_bad_fixed
         $error("cb_const_builder: FIXED_REG outside register index range");
      end
   endgenerate

   cb_sel_t sel;
   logic    legal;

   cb_op_decode u_dec (
      .op    (in_op),
      .sel   (sel),
      .legal (legal)
   );

   logic [XLEN-1:0] r_ins, r_insn, r_acc, r_init, r_ldfix;

   cb_insert_lane #(.XLEN(XLEN), .LIT_W(NARROW_W), .INVERT(1'b0)) u_ins (
      .base (in_src),
      .lit  (in_imm[NARROW_W-1:0]),
      .res  (r_ins)
   );

   cb_insert_lane #(.XLEN(XLEN), .LIT_W(NARROW_W), .INVERT(1'b1)) u_insn (
      .base (in_src),
      .lit  (in_imm[NARROW_W-1:0]),
      .res  (r_insn)
   );

   cb_insert_lane #(.XLEN(XLEN), .LIT_W(WIDE_W), .INVERT(1'b0)) u_acc (
      .base (in_dst),
      .lit  (in_imm[WIDE_W-1:0]),
      .res  (r_acc)
   );

   cb_sext_lane #(.XLEN(XLEN), .LIT_W(WIDE_W)) u_init (
      .lit (in_imm[WIDE_W-1:0]),
      .res (r_init)
   );

   cb_sext_lane #(.XLEN(XLEN), .LIT_W(LOAD_W)) u_ldfix (
      .lit (in_imm[LOAD_W-1:0]),
      .res (r_ldfix)
   );

   // AND-OR select over the one-hot lanes
   logic [XLEN-1:0] result_d;
   always_comb begin
      result_d = ({XLEN{sel.ins}}   & r_ins)
               | ({XLEN{sel.insn}}  & r_insn)
               | ({XLEN{sel.acc}}   & r_acc)
               | ({XLEN{sel.init}}  & r_init)
               | ({XLEN{sel.ldfix}} & r_ldfix);
   end

   logic [RIDX_W-1:0] rd_d;
   assign rd_d = sel.ldfix ? FIXED_IDX : in_rd;

   logic accept;
   assign accept = in_valid & legal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_result <= '0;
         out_rd     <= '0;
      end else begin
         out_valid <= accept;
         if (accept) begin
            out_result <= result_d;
            out_rd     <= rd_d;
         end
      end
   end
endmodule

// File: rtl/cb_const_builder_chk.sv
module cb_const_builder_chk #(
   parameter int XLEN      = 64,
   parameter int NARROW_W  = 16,
   parameter int WIDE_W    = 22,
   parameter int LOAD_W    = 25,
   parameter int IMM_W     = 25,
   parameter int RIDX_W    = 5,
   parameter int FIXED_REG = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [2:0]        in_op,
   input logic [IMM_W-1:0]  in_imm,
   input logic              out_valid,
   input logic [RIDX_W-1:0] out_rd,
   input logic [XLEN-1:0]   out_result
);
   logic ok_op;
   assign ok_op = (in_op <= 3'd4);

   p_accept_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ok_op) |=> out_valid);

   p_idle_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_rd)));

   p_illegal_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !ok_op) |=> (!out_valid && $stable(out_result) && $stable(out_rd)));

   p_fixed_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 3'd4) |=> (out_rd == RIDX_W'(FIXED_REG)));

   p_ins_low_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 3'd0) |=> (out_result[NARROW_W-1:0] == $past(in_imm[NARROW_W-1:0])));

   p_insn_low_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 3'd1) |=> (out_result[NARROW_W-1:0] == ~$past(in_imm[NARROW_W-1:0])));

   p_init_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 3'd3) |=>
         (out_result[XLEN-1:WIDE_W-1] == {(XLEN-WIDE_W+1){$past(in_imm[WIDE_W-1])}}));

   p_acc_low_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 3'd2) |=> (out_result[WIDE_W-1:0] == $past(in_imm[WIDE_W-1:0])));

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_clear_r9: assert (!out_valid && out_result == '0 && out_rd == '0);
      end
   end

   logic unused_hi;
   assign unused_hi = ^in_imm[IMM_W-1:WIDE_W] ^ (LOAD_W > 0);
endmodule

bind cb_const_builder cb_const_builder_chk #(
   .XLEN(XLEN), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .LOAD_W(LOAD_W),
   .IMM_W(IMM_W), .RIDX_W(RIDX_W), .FIXED_REG(FIXED_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_op      (in_op),
   .in_imm     (in_imm),
   .out_valid  (out_valid),
   .out_rd     (out_rd),
   .out_result (out_result)
);

// File: tb/tb_cb_const_builder.sv
`timescale 1ns/1ps
module tb_cb_const_builder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_op = '0;
   logic [4:0]  in_rd = '0;
   logic [63:0] in_src = '0;
   logic [63:0] in_dst = '0;
   logic [24:0] in_imm = '0;
   logic        out_valid;
   logic [4:0]  out_rd;
   logic [63:0] out_result;

   always #2 clk = ~clk;

   cb_const_builder dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_rd(in_rd), .in_src(in_src), .in_dst(in_dst), .in_imm(in_imm),
      .out_valid(out_valid), .out_rd(out_rd), .out_result(out_result)
   );

   int checks = 0;
   int failures = 0;
   string cur_tag = "R9";

   // behavioural reference, bit by bit
   function automatic logic [63:0] m_insert(input logic [63:0] base,
                                            input logic [24:0] imm,
                                            input int w, input bit inv);
      logic [63:0] r;
      for (int i = 0; i < 64; i++)
         r[i] = (i < w) ? (imm[i] ^ inv) : base[i-w];
      return r;
   endfunction

   function automatic logic [63:0] m_sext(input logic [24:0] imm, input int w);
      logic [63:0] r;
      for (int i = 0; i < 64; i++)
         r[i] = (i < w) ? imm[i] : imm[w-1];
      return r;
   endfunction

   logic        exp_valid = 1'b0;
   logic [63:0] exp_res = '0;
   logic [4:0]  exp_rd = '0;
   string       exp_tag = "R9";
   bit          started = 1'b0;

   always @(posedge clk) begin
      started <= 1'b1;
      exp_tag <= cur_tag;
      if (!rst_n) begin
         exp_valid <= 1'b0; exp_res <= '0; exp_rd <= '0;
      end else if (in_valid && in_op <= 3'd4) begin
         exp_valid <= 1'b1;
         exp_rd    <= (in_op == 3'd4) ? 5'd0 : in_rd;
         case (in_op)
            3'd0: exp_res <= m_insert(in_src, in_imm, 16, 1'b0);
            3'd1: exp_res <= m_insert(in_src, in_imm, 16, 1'b1);
            3'd2: exp_res <= m_insert(in_dst, in_imm, 22, 1'b0);
            3'd3: exp_res <= m_sext(in_imm, 22);
            default: exp_res <= m_sext(in_imm, 25);
         endcase
      end else begin
         exp_valid <= 1'b0;
      end
   end

   // cycle-by-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (started) begin
         checks++;
         if (out_valid !== exp_valid || out_result !== exp_res || out_rd !== exp_rd) begin
            failures++;
            $display("FAIL %s: valid=%b result=%h rd=%0d expected valid=%b result=%h rd=%0d",
                     exp_tag, out_valid, out_result, out_rd, exp_valid, exp_res, exp_rd);
         end
      end
   end

   task automatic step(input logic [2:0] op, input logic [63:0] src,
                       input logic [63:0] dst, input logic [24:0] imm,
                       input logic [4:0] rd, input bit src_prev,
                       input bit dst_prev, input string tag);
      @(negedge clk);
      in_valid = 1'b1;
      in_op    = op;
      in_src   = src_prev ? out_result : src;
      in_dst   = dst_prev ? out_result : dst;
      in_imm   = imm;
      in_rd    = rd;
      cur_tag  = tag;
   endtask

   task automatic idle(input string tag);
      @(negedge clk);
      in_valid = 1'b0;
      in_op    = 3'($urandom);
      in_src   = {$urandom, $urandom};
      in_imm   = 25'($urandom);
      cur_tag  = tag;
   endtask

   task automatic final_check(input logic [63:0] c, input string tag);
      @(negedge clk);
      in_valid = 1'b0;
      cur_tag  = tag;
      @(negedge clk);
      checks++;
      if (out_result !== c) begin
         failures++;
         $display("FAIL %s: chain result=%h expected=%h", tag, out_result, c);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : stim
      logic [63:0] c;
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_result !== '0 || out_rd !== '0) begin
         failures++;
         $display("FAIL R9: valid=%b result=%h rd=%0d expected 0 0 0",
                  out_valid, out_result, out_rd);
      end
      @(negedge clk); rst_n = 1'b1;
      idle("R7");

      // R1 insert, with top bits of src discarded
      step(3'd0, 64'hDEAD_BEEF_0123_4567, 64'h0, 25'h0_ABCD, 5'd7, 0, 0, "R1");
      step(3'd0, 64'hFFFF_0000_0000_0001, 64'h0, 25'h0_0000, 5'd1, 0, 0, "R1");
      // R2 inverted insert, field only
      step(3'd1, 64'h0000_0000_1234_5678, 64'h0, 25'h0_00F0, 5'd2, 0, 0, "R2");
      step(3'd4, 64'h0, 64'h0, 25'h1FF_FFFF, 5'd9, 0, 0, "R5");
      step(3'd1, 64'h0, 64'h0, 25'h0_0004, 5'd3, 1, 0, "R2");
      // R3 accumulate uses dst, not src
      step(3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, 25'h2A_5A5A, 5'd4, 0, 0, "R3");
      // R4 initial load, both signs
      step(3'd3, 64'hFFFF, 64'hFFFF, 25'h20_0001, 5'd5, 0, 0, "R4");
      step(3'd3, 64'h0, 64'h0, 25'h1F_FFFF, 5'd6, 0, 0, "R4");
      // R5 fixed load, both signs, rd forced
      step(3'd4, 64'h0, 64'h0, 25'h100_0000, 5'd31, 0, 0, "R5");
      step(3'd4, 64'h0, 64'h0, 25'h0FF_FFFF, 5'd17, 0, 0, "R5");
      // R6 garbage above used field
      step(3'd0, 64'h5, 64'h0, 25'h1FF_1234, 5'd8, 0, 0, "R6");
      step(3'd1, 64'h5, 64'h0, 25'h1AB_1234, 5'd8, 0, 0, "R6");
      step(3'd2, 64'h0, 64'h9, 25'h1C0_0001, 5'd8, 0, 0, "R6");
      step(3'd3, 64'h0, 64'h0, 25'h1C0_0001, 5'd8, 0, 0, "R6");
      // R8 illegal codes hold output
      step(3'd5, 64'h1, 64'h1, 25'h1, 5'd1, 0, 0, "R8");
      step(3'd6, 64'h2, 64'h2, 25'h2, 5'd2, 0, 0, "R8");
      step(3'd7, 64'h3, 64'h3, 25'h3, 5'd3, 0, 0, "R8");
      // R7 idle with noise
      idle("R7"); idle("R7");

      for (int n = 0; n < 8; n++) begin
         c = (n == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : {$urandom, $urandom};
         step(3'd0, 64'h0, 64'h0, {9'h0, c[63:48]}, 5'd10, 0, 0, "R10");
         step(3'd0, 64'h0, 64'h0, {9'h0, c[47:32]}, 5'd10, 1, 0, "R10");
         step(3'd0, 64'h0, 64'h0, {9'h0, c[31:16]}, 5'd10, 1, 0, "R10");
         step(3'd0, 64'h0, 64'h0, {9'h0, c[15:0]},  5'd10, 1, 0, "R10");
         final_check(c, "R10");
      end

      for (int n = 0; n < 8; n++) begin
         c = (n == 0) ? 64'h8000_0000_0000_0001 : {$urandom, $urandom};
         step(3'd3, 64'h0, 64'h0, {3'h0, c[63], c[63], c[63:44]}, 5'd11, 0, 0, "R11");
         step(3'd2, 64'h0, 64'h0, {3'h0, c[43:22]}, 5'd11, 0, 1, "R11");
         step(3'd2, 64'h0, 64'h0, {3'h0, c[21:0]},  5'd11, 0, 1, "R11");
         final_check(c, "R11");
      end

      idle("R7");
      @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule